// File: doc/BRIEF.md
# PLCP Path Status Byte Generator

This block assembles the path status byte that a DS3 PLCP transmitter sends once in every PLCP frame. A frame strobe marks the moment the byte is due. On that strobe the block samples the BIP-8 error count reported by the local receive side and the local receive framing-fault flag, and combines them with three software-written link bits. It then presents the finished byte on a registered output that holds until the next strobe.

A small 8-bit control register, written and read through a simple register port, lets software shape the byte. One bit forces the error field to zero, whatever errors the receiver sees. Another bit forces the remote alarm indication on. Three bits pass straight through to the far-end receiver and form a low-rate data channel. The error count is clipped at 8, the largest count a frame can legally report. Computing the BIP-8 sums, PLCP framing and serializing the byte into the line are left to neighbouring blocks.

Top module: `plcp_status_gen`

## Requirements
- R1: After reset, `regRdData` reads 0x00, `statusByte` is 0x00 and `statusValid` is 0.
- R2: A write with `regWrEn` high stores bits 4..0 of `regWrData`. From the next cycle, `regRdData` returns them in bits 4..0. Bits 7..5 always read 0, whatever was written. Register layout: bit 4 = error mask, bit 3 = alarm force, bits 2..0 = link bits.
- R3: With the error mask at 0, bits 7..4 of the byte loaded at a strobe equal the sampled `rxErrCount` when it is 8 or less, and 8 when it is larger.
- R4: With the error mask at 1, bits 7..4 of the loaded byte are 0 for any error count.
- R5: With the alarm force bit at 1, bit 3 of the loaded byte is 1 whatever the state of `rxFrameFault`.
- R6: With the alarm force bit at 0, bit 3 of the loaded byte equals `rxFrameFault` as sampled at the strobe.
- R7: Bits 2..0 of the loaded byte equal the link bits held in the register.
- R8: `statusByte` changes only on a clock edge where `frameStrobe` is high, taking the new value one cycle after the strobe. `statusValid` is high for exactly the cycle after each strobe. Between strobes, changes to the count, fault flag or register leave `statusByte` unchanged.
- R9: When a register write and a strobe fall in the same cycle, the loaded byte uses the register contents from before the write. The new contents apply from the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| frameStrobe | input | 1 | One-cycle pulse marking the status byte slot |
| rxErrCount | input | 4 | BIP-8 error count from the local receive side |
| rxFrameFault | input | 1 | Local receive framing fault |
| statusByte | output | 8 | Assembled path status byte |
| statusValid | output | 1 | High for the cycle after a strobe |

## Verification
On every cycle the assertions check these properties: the error field never exceeds 8; masking zeroes the field; the force bit sets the alarm bit; otherwise the alarm bit follows the sampled fault; the link bits pass through; the byte holds between strobes; and register writes read back with the upper bits cleared. Some behaviour only the bench scenarios can show. These are the exact clipping of large counts, pass-through values for particular counts, the ordering of a write against a strobe in the same cycle, and the reset values.

// File: rtl/plcp_status_pkg.sv
package plcp_status_pkg;
  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic load;        // capture a new status byte this edge
    logic maskErr;     // force error field to zero
    logic forceAlarm;  // force remote alarm bit on
  } ctrlStrb_t;
endpackage

// File: rtl/plcp_status_ctrl.sv
module plcp_status_ctrl
  import plcp_status_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int LINK_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              frameStrobe,
  output ctrlStrb_t         strb,
  output logic [LINK_W-1:0] linkBits
);
  localparam int ALARM_BIT = LINK_W;
  localparam int MASK_BIT  = LINK_W + 1;
  localparam int USED_W    = LINK_W + 2;
  localparam logic [REG_W-1:0] USED_MASK = REG_W'((1 << USED_W) - 1);

  logic [REG_W-1:0] cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (wrEn) begin
      cfgReg <= wrData & USED_MASK;
    end
  end

  assign rdData          = cfgReg;
  assign strb.load       = frameStrobe;
  assign strb.maskErr    = cfgReg[MASK_BIT];
  assign strb.forceAlarm = cfgReg[ALARM_BIT];
  assign linkBits        = cfgReg[LINK_W-1:0];

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == ($past(wrData) & USED_MASK)); // R2
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData & ~USED_MASK) == '0); // R2
endmodule

// File: rtl/plcp_status_dp.sv
module plcp_status_dp
  import plcp_status_pkg::*;
#(
  parameter int ERR_W   = 4,
  parameter int FIELD_W = 4,
  parameter int LINK_W  = 3,
  parameter int ERR_MAX = 8,
  localparam int OUT_W  = FIELD_W + 1 + LINK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [LINK_W-1:0] linkBits,
  input  logic [ERR_W-1:0]  errCount,
  input  logic              frameFault,
  output logic [OUT_W-1:0]  statusByte,
  output logic              statusValid
);
  localparam int ALARM_POS = LINK_W;
  localparam int FIELD_HI  = OUT_W - 1;

  logic [FIELD_W-1:0] errClip;
  logic [FIELD_W-1:0] errField;
  logic               alarmBit;

  generate
    if (((1 << ERR_W) - 1) > ERR_MAX) begin : g_clip
      always_comb begin
        if (errCount > ERR_W'(ERR_MAX)) errClip = FIELD_W'(ERR_MAX);
        else                            errClip = FIELD_W'(errCount);
      end
    end else begin : g_pass
      assign errClip = FIELD_W'(errCount);
    end
  endgenerate

  assign errField = strb.maskErr ? '0 : errClip;
  assign alarmBit = strb.forceAlarm | frameFault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusByte  <= '0;
      statusValid <= 1'b0;
    end else begin
      statusValid <= strb.load;
      if (strb.load) statusByte <= {errField, alarmBit, linkBits};
    end
  end

  AST_FIELD_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[FIELD_HI -: FIELD_W] <= FIELD_W'(ERR_MAX)); // R3
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.maskErr) |=> statusByte[FIELD_HI -: FIELD_W] == '0); // R4
  AST_ALARM_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.forceAlarm) |=> statusByte[ALARM_POS]); // R5
  AST_FAULT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.forceAlarm) |=> statusByte[ALARM_POS] == $past(frameFault)); // R6
  AST_LINK_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> statusByte[LINK_W-1:0] == $past(linkBits)); // R7
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(statusByte)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> statusValid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !statusValid); // R8
endmodule

// File: rtl/plcp_status_gen.sv
module plcp_status_gen
  import plcp_status_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int ERR_W   = 4,
  parameter int FIELD_W = 4,
  parameter int LINK_W  = 3,
  parameter int ERR_MAX = 8,
  localparam int OUT_W  = FIELD_W + 1 + LINK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              frameStrobe,
  input  logic [ERR_W-1:0]  rxErrCount,
  input  logic              rxFrameFault,
  output logic [OUT_W-1:0]  statusByte,
  output logic              statusValid
);
  ctrlStrb_t         strb;
  logic [LINK_W-1:0] linkBits;

  plcp_status_ctrl #(.REG_W(REG_W), .LINK_W(LINK_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (regWrEn),
    .wrData     (regWrData),
    .rdData     (regRdData),
    .frameStrobe(frameStrobe),
    .strb       (strb),
    .linkBits   (linkBits)
  );

  plcp_status_dp #(.ERR_W(ERR_W), .FIELD_W(FIELD_W), .LINK_W(LINK_W),
                   .ERR_MAX(ERR_MAX)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .linkBits   (linkBits),
    .errCount   (rxErrCount),
    .frameFault (rxFrameFault),
    .statusByte (statusByte),
    .statusValid(statusValid)
  );
endmodule

// File: tb/sim_plcp_status_gen.sv
module sim_plcp_status_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [7:0] cfg;
    logic [3:0] cnt;
    logic       fault;
    logic [7:0] exp;
  } vec_t;

  // cfg: bit4 mask, bit3 force alarm, bits2..0 link; expected byte = {field, alarm, link}
  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 4'd0,  1'b0, 8'h00},  // R3 zero
    '{8'h00, 4'd3,  1'b0, 8'h30},  // R3 pass
    '{8'h00, 4'd8,  1'b1, 8'h88},  // R3 limit, R6 fault
    '{8'h00, 4'd12, 1'b0, 8'h80},  // R3 clip
    '{8'h00, 4'd15, 1'b1, 8'h88},  // R3 clip, R6
    '{8'h10, 4'd5,  1'b0, 8'h00},  // R4 mask
    '{8'h10, 4'd15, 1'b1, 8'h08},  // R4 mask, R6
    '{8'h08, 4'd0,  1'b0, 8'h08},  // R5 force
    '{8'h08, 4'd2,  1'b1, 8'h28},  // R5 with fault
    '{8'h05, 4'd1,  1'b0, 8'h15},  // R7 link
    '{8'h07, 4'd9,  1'b1, 8'h8F},  // R7, R3 clip
    '{8'h1F, 4'd7,  1'b0, 8'h0F},  // R4, R5, R7
    '{8'hE2, 4'd4,  1'b0, 8'h42},  // R2 high bits ignored, R7
    '{8'h03, 4'd0,  1'b1, 8'h0B}   // R6, R7
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       frameStrobe;
  logic [3:0] rxErrCount;
  logic       rxFrameFault;
  logic [7:0] statusByte;
  logic       statusValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plcp_status_gen u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .frameStrobe(frameStrobe), .rxErrCount(rxErrCount),
    .rxFrameFault(rxFrameFault), .statusByte(statusByte), .statusValid(statusValid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic strobe(input logic [3:0] c, input logic f);
    @(negedge clk);
    frameStrobe = 1'b1; rxErrCount = c; rxFrameFault = f;
    @(negedge clk);
    frameStrobe = 1'b0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0; frameStrobe = 1'b0;
    rxErrCount = '0; rxFrameFault = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 regRdData", regRdData, 8'h00);
    chk("R1 statusByte", statusByte, 8'h00);
    chk("R1 statusValid", {7'd0, statusValid}, 8'h00);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      regWrite(VECS[i].cfg);
      chk("R2 readback", regRdData, VECS[i].cfg & 8'h1F);
      strobe(VECS[i].cnt, VECS[i].fault);
      chk("R3/R4/R5/R6/R7 byte", statusByte, VECS[i].exp);
      chk("R8 valid pulse", {7'd0, statusValid}, 8'h01);
    end

    // R2 all ones write: upper bits read zero
    regWrite(8'hFF);
    chk("R2 upper bits", regRdData, 8'h1F);

    // R8 hold: no strobe, inputs and register change
    regWrite(8'h00);
    strobe(4'd6, 1'b1);
    chk("R8 setup", statusByte, 8'h68);
    @(negedge clk);
    rxErrCount = 4'd2; rxFrameFault = 1'b0;
    regWrite(8'h17);
    repeat (3) @(negedge clk);
    chk("R8 hold byte", statusByte, 8'h68);
    chk("R8 valid idle", {7'd0, statusValid}, 8'h00);

    // R9 write and strobe in same cycle: old register used
    regWrite(8'h00);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = 8'h1D;
    frameStrobe = 1'b1; rxErrCount = 4'd3; rxFrameFault = 1'b0;
    @(negedge clk);
    regWrEn = 1'b0; frameStrobe = 1'b0;
    chk("R9 old config", statusByte, 8'h30);
    strobe(4'd3, 1'b0);
    chk("R9 new config", statusByte, 8'h0D);

    // R1 reset mid-operation clears state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset again reg", regRdData, 8'h00);
    chk("R1 reset again byte", statusByte, 8'h00);

    finish();
  end
endmodule